// File: doc/BRIEF.md
# Paged Write Buffer and Address Counter

This block sits behind a serial slave front end and in front of a byte-addressed non-volatile style memory array. It owns the current byte address counter, gathers write data for one page into a local buffer, and after a commit request copies the buffered page into the array during a timed busy window. Reads are served straight from the array, one byte per strobe, with the counter stepping after each byte.

The array is split into pages of 128 bytes, and each page into aligned 4-byte groups. Write addressing only moves the seven in-page offset bits, so a long burst wraps inside its page and later bytes replace earlier ones. Read addressing steps the whole counter and rolls over the end of the array. At commit, a sequencer visits every group of the buffered page once. For each group that holds at least one buffered byte it reads the stored group, replaces the buffered bytes and writes all four bytes back. The busy window lasts a number of clock cycles derived from the clock frequency and the programming time, so a bench can shorten it.

The array size is the parameter `ADDR_W`. With `ADDR_W = 16` it holds 64 KiB in 512 pages, and the default of 11 gives 2 KiB in 16 pages. The sequencer states are `PS_IDLE` (accepting strobes), `PS_WALK` (one group per cycle, the whole page) and `PS_SETTLE` (waiting out the rest of the busy time). The transitions are `PS_IDLE`→`PS_WALK` on a commit with buffered data, `PS_WALK`→`PS_SETTLE` after the last group, and `PS_SETTLE`→`PS_IDLE` when the timer reaches zero, which also empties the buffer.

Top module: `page_store`

## Requirements
- R1: After reset `busy_o` is 0, the counter is 0 and every array byte reads as 0xFF.
- R2: A load strobe sets the counter to `ld_addr_i`. A read strobe returns the array byte at the counter on `rd_data_o` in the cycle after the strobe.
- R3: Each accepted read adds one to the whole counter, so reads cross page boundaries and step from the last address to 0.
- R4: An accepted write stores `wr_data_i` in the buffer at the counter's offset (bits 6..0) and adds one to those bits only, wrapping from 127 to 0 with the page bits unchanged. A later byte at the same offset replaces the earlier one. The target page is the counter's page when the first byte of the batch is buffered.
- R5: Buffered bytes do not reach the array before a commit. A read before the commit returns the old contents.
- R6: A commit strobe while the buffer holds data raises `busy_o` in the next cycle for exactly `BUSY_CYC` cycles (clock frequency in MHz times the write time in µs, but at least one more than the groups per page). A commit with an empty buffer leaves `busy_o` low.
- R7: A commit rewrites only the 4-byte aligned groups that hold buffered bytes. Bytes of such a group that were not written keep their old values, and the other groups are unchanged.
- R8: While `busy_o` is 1, load, write, read and commit strobes are ignored: the counter and the buffer keep their values.
- R9: After an operation the counter points at the byte after the last one accessed. A read with no load that follows a write batch returns the byte after the last written one.
- R10: When several strobes arrive in one cycle only one acts, in the priority order commit, load, write, read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_i | input | 1 | Load-address strobe |
| ld_addr_i | input | ADDR_W | Address loaded into the counter |
| wr_i | input | 1 | Write-byte strobe |
| wr_data_i | input | 8 | Byte to buffer |
| rd_i | input | 1 | Read-byte strobe |
| commit_i | input | 1 | Commit request (end of a write transfer) |
| rd_data_o | output | 8 | Byte returned by the last read |
| busy_o | output | 1 | Array write in progress |

## Verification
If the counter goes wrong, the data on `rd_data_o` is wrong on the next read, one cycle after the strobe. This can come from an increment in the wrong field, a missing rollover or a strobe taken while busy. If the buffer, its valid flags or the merge go wrong, nothing shows until the commit has finished and the affected bytes are read back: bytes next to a written one come back changed, or bytes are missing or land at the wrong offset. A busy window that starts late or has the wrong length shows at once on `busy_o`. So does an empty commit that starts a busy window.

// File: rtl/pstore_pkg.sv
package pstore_pkg;

    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_WALK   = 2'd1,
        PS_SETTLE = 2'd2
    } pstate_t;

    localparam int GRP_BYTES = 4;
    localparam int GRP_BITS  = 8 * GRP_BYTES;

    function automatic logic [GRP_BITS-1:0] merge_group(
        input logic [GRP_BITS-1:0]  old_word,
        input logic [GRP_BITS-1:0]  new_word,
        input logic [GRP_BYTES-1:0] keep_new
    );
        logic [GRP_BITS-1:0] res;
        for (int b = 0; b < GRP_BYTES; b++) begin
            res[8*b +: 8] = keep_new[b] ? new_word[8*b +: 8] : old_word[8*b +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/pstore_addr_ctr.sv
module pstore_addr_ctr #(
    parameter int ADDR_W = 11,
    parameter int OFF_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [ADDR_W-1:0] ld_val_i,
    input  logic              wstep_i,
    input  logic              rstep_i,
    output logic [ADDR_W-1:0] cnt_o
);

    logic [ADDR_W-1:0] cnt_q;
    logic [OFF_W-1:0]  off_inc;
    logic [ADDR_W-1:0] full_inc;

    assign off_inc  = cnt_q[OFF_W-1:0] + 1'b1;
    assign full_inc = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end else if (wstep_i) begin
            cnt_q[OFF_W-1:0] <= off_inc;
        end else if (rstep_i) begin
            cnt_q <= full_inc;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pstore_wbuf.sv
module pstore_wbuf #(
    parameter int PAGE_BYTES = 128,
    parameter int OFF_W      = 7,
    parameter int GIDX_W     = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [OFF_W-1:0]              off_i,
    input  logic [7:0]                    data_i,
    input  logic                          clr_i,
    input  logic [GIDX_W-1:0]             grp_i,
    output logic [pstore_pkg::GRP_BITS-1:0]  grp_data_o,
    output logic [pstore_pkg::GRP_BYTES-1:0] grp_vld_o,
    output logic                          any_o
);

    localparam int LANE_W = OFF_W - GIDX_W;

    logic [7:0]            bytes_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (clr_i) begin
            vld_q <= '0;
        end else if (we_i) begin
            vld_q[off_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we_i && !clr_i) begin
            bytes_q[off_i] <= data_i;
        end
    end

    for (genvar l = 0; l < pstore_pkg::GRP_BYTES; l++) begin : g_lane
        logic [OFF_W-1:0] idx;
        assign idx                = {grp_i, LANE_W'(l)};
        assign grp_data_o[8*l +: 8] = bytes_q[idx];
        assign grp_vld_o[l]       = vld_q[idx];
    end

    assign any_o = |vld_q;

endmodule

// File: rtl/pstore_array.sv
module pstore_array #(
    parameter int ADDR_W = 11
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                rd_addr_i,
    output logic [7:0]                       rd_byte_o,
    input  logic [ADDR_W-3:0]                g_addr_i,
    output logic [pstore_pkg::GRP_BITS-1:0]  g_rdata_o,
    input  logic                             g_we_i,
    input  logic [pstore_pkg::GRP_BITS-1:0]  g_wdata_i
);

    localparam int WADDR_W = ADDR_W - 2;
    localparam int NWORDS  = 1 << WADDR_W;

    logic [pstore_pkg::GRP_BITS-1:0] words_q [NWORDS];
    logic [pstore_pkg::GRP_BITS-1:0] rd_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWORDS; w++) begin
                words_q[w] <= '1;
            end
        end else if (g_we_i) begin
            words_q[g_addr_i] <= g_wdata_i;
        end
    end

    assign rd_word   = words_q[rd_addr_i[ADDR_W-1:2]];
    assign rd_byte_o = rd_word[{rd_addr_i[1:0], 3'b000} +: 8];
    assign g_rdata_o = words_q[g_addr_i];

endmodule

// File: rtl/pstore_seq.sv
module pstore_seq
    import pstore_pkg::*;
#(
    parameter int GIDX_W   = 5,
    parameter int BUSY_CYC = 40,
    parameter int TMR_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [GRP_BYTES-1:0] grp_vld_i,
    input  logic [GRP_BITS-1:0]  buf_word_i,
    input  logic [GRP_BITS-1:0]  arr_word_i,
    output logic [GIDX_W-1:0]    grp_o,
    output logic                 busy_o,
    output logic                 we_o,
    output logic [GRP_BITS-1:0]  wdata_o,
    output logic                 clr_o
);

    localparam logic [GIDX_W-1:0] LAST_GRP = '1;
    localparam logic [TMR_W-1:0]  TMR_INIT = TMR_W'(BUSY_CYC - 1);

    pstate_t           state_q, state_d;
    logic [TMR_W-1:0]  tmr_q, tmr_d;
    logic [GIDX_W-1:0] grp_q, grp_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            tmr_q   <= '0;
            grp_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            grp_q   <= grp_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        grp_d   = grp_q;
        unique case (state_q)
            PS_IDLE: begin
                if (start_i) begin
                    state_d = PS_WALK;
                    tmr_d   = TMR_INIT;
                    grp_d   = '0;
                end
            end
            PS_WALK: begin
                tmr_d = tmr_q - 1'b1;
                if (grp_q == LAST_GRP) begin
                    state_d = PS_SETTLE;
                end else begin
                    grp_d = grp_q + 1'b1;
                end
            end
            PS_SETTLE: begin
                if (tmr_q == '0) begin
                    state_d = PS_IDLE;
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        busy_o  = (state_q != PS_IDLE);
        grp_o   = grp_q;
        we_o    = (state_q == PS_WALK) && (|grp_vld_i);
        wdata_o = merge_group(arr_word_i, buf_word_i, grp_vld_i);
        clr_o   = (state_q == PS_SETTLE) && (tmr_q == '0);
    end

endmodule

// File: rtl/page_store.sv
module page_store #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 128,
    parameter int CLK_HZ     = 50_000_000,
    parameter int WR_TIME_US = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic              wr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              rd_i,
    input  logic              commit_i,
    output logic [7:0]        rd_data_o,
    output logic              busy_o
);

    import pstore_pkg::*;

    localparam int OFF_W    = $clog2(PAGE_BYTES);
    localparam int PAGE_W   = ADDR_W - OFF_W;
    localparam int LANE_W   = $clog2(GRP_BYTES);
    localparam int GIDX_W   = OFF_W - LANE_W;
    localparam int WADDR_W  = ADDR_W - LANE_W;
    localparam int GPP      = 1 << GIDX_W;
    localparam int RAW_CYC  = (CLK_HZ / 1_000_000) * WR_TIME_US;
    localparam int BUSY_CYC = (RAW_CYC > GPP) ? RAW_CYC : GPP + 1;
    localparam int TMR_W    = $clog2(BUSY_CYC + 1);

    logic [ADDR_W-1:0]    cnt_q;
    logic [PAGE_W-1:0]    page_q;
    logic [7:0]           rd_data_q;
    logic                 busy;
    logic                 any_vld;
    logic                 do_commit, do_ld, do_wr, do_rd;
    logic [GIDX_W-1:0]    grp_idx;
    logic [GRP_BYTES-1:0] grp_vld;
    logic [GRP_BITS-1:0]  buf_word, arr_word, new_word;
    logic                 arr_we, buf_clr;
    logic [7:0]           arr_byte;
    logic [WADDR_W-1:0]   g_addr;

    // strobe arbitration: commit > load > write > read, all blocked while busy
    assign do_commit = commit_i && !busy && any_vld;
    assign do_ld     = ld_i && !busy && !commit_i;
    assign do_wr     = wr_i && !busy && !commit_i && !ld_i;
    assign do_rd     = rd_i && !busy && !commit_i && !ld_i && !wr_i;

    pstore_addr_ctr #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (do_ld),
        .ld_val_i (ld_addr_i),
        .wstep_i  (do_wr),
        .rstep_i  (do_rd),
        .cnt_o    (cnt_q)
    );

    // target page is fixed by the first byte of a batch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (do_wr && !any_vld) begin
            page_q <= cnt_q[ADDR_W-1:OFF_W];
        end
    end

    pstore_wbuf #(
        .PAGE_BYTES (PAGE_BYTES),
        .OFF_W      (OFF_W),
        .GIDX_W     (GIDX_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (do_wr),
        .off_i      (cnt_q[OFF_W-1:0]),
        .data_i     (wr_data_i),
        .clr_i      (buf_clr),
        .grp_i      (grp_idx),
        .grp_data_o (buf_word),
        .grp_vld_o  (grp_vld),
        .any_o      (any_vld)
    );

    assign g_addr = {page_q, grp_idx};

    pstore_array #(
        .ADDR_W (ADDR_W)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (cnt_q),
        .rd_byte_o (arr_byte),
        .g_addr_i  (g_addr),
        .g_rdata_o (arr_word),
        .g_we_i    (arr_we),
        .g_wdata_i (new_word)
    );

    pstore_seq #(
        .GIDX_W   (GIDX_W),
        .BUSY_CYC (BUSY_CYC),
        .TMR_W    (TMR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (do_commit),
        .grp_vld_i  (grp_vld),
        .buf_word_i (buf_word),
        .arr_word_i (arr_word),
        .grp_o      (grp_idx),
        .busy_o     (busy),
        .we_o       (arr_we),
        .wdata_o    (new_word),
        .clr_o      (buf_clr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= 8'hFF;
        end else if (do_rd) begin
            rd_data_q <= arr_byte;
        end
    end

    assign rd_data_o = rd_data_q;
    assign busy_o    = busy;

endmodule

// File: rtl/page_store_chk.sv
module page_store_chk #(
    parameter int ADDR_W   = 11,
    parameter int OFF_W    = 7,
    parameter int BUSY_CYC = 101
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_i,
    input logic [ADDR_W-1:0] ld_addr_i,
    input logic              wr_i,
    input logic              rd_i,
    input logic              commit_i,
    input logic              busy_o,
    input logic [ADDR_W-1:0] cnt,
    input logic              any_vld,
    input logic              arr_we
);

    logic [ADDR_W-1:0] cnt_inc;
    logic [OFF_W-1:0]  off_inc;
    logic [31:0]       run_q;
    logic              idle_ok;

    assign cnt_inc = cnt + 1'b1;
    assign off_inc = cnt[OFF_W-1:0] + 1'b1;
    assign idle_ok = !busy_o && !commit_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= '0;
        end
    end

    AST_LOAD_SETS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && idle_ok) |=> cnt == $past(ld_addr_i)); // R2

    AST_READ_STEPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && idle_ok && !ld_i && !wr_i) |=> cnt == $past(cnt_inc)); // R3

    AST_WRITE_STAYS_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && idle_ok && !ld_i) |=> (cnt[ADDR_W-1:OFF_W] == $past(cnt[ADDR_W-1:OFF_W]))
                                      && (cnt[OFF_W-1:0] == $past(off_inc))); // R4

    AST_ARRAY_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy_o); // R5

    AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !busy_o && any_vld) |=> busy_o); // R6

    AST_EMPTY_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !busy_o && !any_vld) |=> !busy_o); // R6

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> run_q == BUSY_CYC); // R6

    AST_BUSY_FREEZES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(cnt)); // R8

endmodule

bind page_store page_store_chk #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .BUSY_CYC (BUSY_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_i      (ld_i),
    .ld_addr_i (ld_addr_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .commit_i  (commit_i),
    .busy_o    (busy_o),
    .cnt       (cnt_q),
    .any_vld   (any_vld),
    .arr_we    (arr_we)
);

// File: tb/page_store_bench.sv
module page_store_bench;

    localparam int ADDR_W = 11;
    localparam int BUSY   = 100;   // 50 MHz x 2 us

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_i = 1'b0;
    logic [ADDR_W-1:0] ld_addr_i = '0;
    logic              wr_i = 1'b0;
    logic [7:0]        wr_data_i = '0;
    logic              rd_i = 1'b0;
    logic              commit_i = 1'b0;
    logic [7:0]        rd_data_o;
    logic              busy_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    page_store #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (128),
        .CLK_HZ     (50_000_000),
        .WR_TIME_US (2)
    ) u_page_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_i      (ld_i),
        .ld_addr_i (ld_addr_i),
        .wr_i      (wr_i),
        .wr_data_i (wr_data_i),
        .rd_i      (rd_i),
        .commit_i  (commit_i),
        .rd_data_o (rd_data_o),
        .busy_o    (busy_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic ld(input logic [ADDR_W-1:0] a);
        @(negedge clk); ld_i = 1'b1; ld_addr_i = a;
        @(negedge clk); ld_i = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_i = 1'b1; wr_data_i = d;
        @(negedge clk); wr_i = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] exp);
        @(negedge clk); rd_i = 1'b1;
        @(negedge clk); rd_i = 1'b0;
        check(tag, rd_data_o, exp);
    endtask

    task automatic commit_len(output int n);
        @(negedge clk); commit_i = 1'b1;
        @(negedge clk); commit_i = 1'b0;
        n = 0;
        while (busy_o && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1 busy after reset", busy_o, 0);
        rd_chk("R1 byte 0 erased", 8'hFF);
        rd_chk("R1 byte 1 erased", 8'hFF);
        ld(11'h7FF);
        rd_chk("R1 last byte erased", 8'hFF);
    endtask

    task automatic t_page_write();
        int n;
        ld(11'h105);
        wr(8'hA1); wr(8'hB2); wr(8'hC3);
        ld(11'h105);
        rd_chk("R5 before commit", 8'hFF);
        commit_len(n);
        check("R6 busy length", n, BUSY);
        ld(11'h104);
        rd_chk("R7 neighbour kept", 8'hFF);
        rd_chk("R2 byte 0x105", 8'hA1);
        rd_chk("R2 byte 0x106", 8'hB2);
        rd_chk("R2 byte 0x107", 8'hC3);
        rd_chk("R7 next group untouched", 8'hFF);
    endtask

    task automatic t_wrap_write();
        int n;
        ld(11'h000); wr(8'h5A); commit_len(n);
        ld(11'h27E);
        wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
        commit_len(n);
        ld(11'h27E);
        rd_chk("R4 offset 7E", 8'h11);
        rd_chk("R4 offset 7F", 8'h22);
        rd_chk("R3 read crosses page", 8'hFF);
        ld(11'h200);
        rd_chk("R4 wrapped to offset 0", 8'h33);
        rd_chk("R4 wrapped to offset 1", 8'h44);
    endtask

    task automatic t_overwrite();
        int n;
        ld(11'h300);
        for (int i = 0; i < 130; i++) wr(8'(i));
        commit_len(n);
        check("R6 long batch busy", n, BUSY);
        rd_chk("R9 counter after batch", 8'h02);
        ld(11'h300);
        rd_chk("R4 overwrite offset 0", 8'h80);
        rd_chk("R4 overwrite offset 1", 8'h81);
        ld(11'h37F);
        rd_chk("R4 offset 127", 8'h7F);
    endtask

    task automatic t_read_wrap();
        ld(11'h7FE);
        rd_chk("R3 0x7FE", 8'hFF);
        rd_chk("R3 0x7FF", 8'hFF);
        rd_chk("R3 rollover to 0", 8'h5A);
        rd_chk("R3 then 1", 8'hFF);
    endtask

    task automatic t_empty_commit();
        int n;
        commit_len(n);
        check("R6 empty commit no busy", n, 0);
    endtask

    task automatic t_busy_ignore();
        ld(11'h400);
        wr(8'h11);
        @(negedge clk); commit_i = 1'b1;
        @(negedge clk); commit_i = 1'b0;
        check("R6 busy after commit", busy_o, 1);
        @(negedge clk); ld_i = 1'b1; ld_addr_i = 11'h010;
        @(negedge clk); ld_i = 1'b0; wr_i = 1'b1; wr_data_i = 8'h77;
        @(negedge clk); wr_i = 1'b0; rd_i = 1'b1;
        @(negedge clk); rd_i = 1'b0; commit_i = 1'b1;
        @(negedge clk); commit_i = 1'b0;
        while (busy_o) @(negedge clk);
        rd_chk("R8 counter unchanged", 8'hFF);
        begin
            int n;
            commit_len(n);
            check("R8 write while busy dropped", n, 0);
        end
        ld(11'h400);
        rd_chk("R8 committed byte", 8'h11);
    endtask

    task automatic t_page_latch();
        int n;
        ld(11'h180); wr(8'h21);
        ld(11'h705); wr(8'h22);
        commit_len(n);
        ld(11'h185);
        rd_chk("R4 page fixed by first byte", 8'h22);
        ld(11'h705);
        rd_chk("R4 other page untouched", 8'hFF);
    endtask

    task automatic t_priority();
        int n;
        ld(11'h500); wr(8'h9C); commit_len(n);
        @(negedge clk); ld_i = 1'b1; ld_addr_i = 11'h500; wr_i = 1'b1; wr_data_i = 8'h33;
        @(negedge clk); ld_i = 1'b0; wr_i = 1'b0;
        rd_chk("R10 load beats write", 8'h9C);
        commit_len(n);
        check("R10 write dropped", n, 0);
        ld(11'h600);
        @(negedge clk); wr_i = 1'b1; wr_data_i = 8'h44; rd_i = 1'b1;
        @(negedge clk); wr_i = 1'b0; rd_i = 1'b0;
        commit_len(n);
        check("R10 write beats read", n, BUSY);
        ld(11'h600);
        rd_chk("R10 written byte", 8'h44);
        ld(11'h640); wr(8'h55);
        @(negedge clk); commit_i = 1'b1; ld_i = 1'b1; ld_addr_i = 11'h000;
        @(negedge clk); commit_i = 1'b0; ld_i = 1'b0;
        check("R10 commit starts busy", busy_o, 1);
        while (busy_o) @(negedge clk);
        rd_chk("R10 commit beats load", 8'hFF);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_page_write();
        t_wrap_write();
        t_overwrite();
        t_read_wrap();
        t_empty_commit();
        t_busy_ignore();
        t_page_latch();
        t_priority();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule